// File: doc/BRIEF.md
# Frame-Synced Serial Channel Buffer

This block is the word buffer for one channel of a synchronous serial port. It works as a transmit channel or as a receive channel, chosen by a mode input. In transmit mode the processor writes words into the buffer. Each frame-sync strobe moves the oldest word out to the serial side. In receive mode each frame-sync strobe captures a word from the serial side, and the processor reads the oldest word out. The bit shifter is not part of the block. Its only trace is a word-wide transfer on every frame-sync pulse, whether the pulse is made inside the chip or arrives from outside.

The buffer holds two words. It reports its fill level as a two-bit code and keeps a sticky error flag. The flag records an underflow in transmit mode and an overflow in receive mode. An overflow does not drop the incoming word: the new word replaces the newest stored word. Both status outputs are read-only. The flag clears on a one-cycle clear strobe or when the channel is disabled. Disabling the channel also empties the buffer.

Top module: `fsync_chan_buf`

## Requirements
- R1: After reset, the fill code is 00, the error flag is 0 and the transmit word output is 0.
- R2: The fill code reads 00 when no word is held, 10 when exactly one word is held and 11 when two words are held. The code 01 never appears.
- R3: In transmit mode (mode input 0), a processor write stores the word when the buffer is not full. A frame-sync strobe with at least one word held puts the oldest word on the transmit word output at the next clock edge. Words leave in the order they were written.
- R4: In transmit mode, a frame-sync strobe while the buffer is empty sets the error flag. The transmit word output keeps its previous value and the buffer stays empty, unless a write in the same cycle adds a word.
- R5: In receive mode (mode input 1), a frame-sync strobe with the buffer not full stores the serial input word. The read data output always shows the oldest held word, and a processor read removes that word.
- R6: In receive mode, a frame-sync strobe while the buffer is full and no read happens in the same cycle sets the error flag. The new word replaces the newest held word, the oldest word is kept and the fill code stays 11.
- R7: The error flag stays set until the clear strobe is applied or the channel is disabled. If a new error and the clear strobe come in the same cycle, the flag ends up set.
- R8: When a processor access and a frame-sync transfer happen in the same cycle, both take effect and the fill level changes by their net amount.
- R9: A write to a full transmit buffer, a read from an empty receive buffer, a read in transmit mode and a write in receive mode are all ignored and leave the fill code unchanged.
- R10: While the enable input is low, the buffer is emptied, the error flag is cleared and the transmit word output is forced to 0. Processor accesses and frame-sync strobes have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low empties the buffer and clears the error flag |
| is_rx | input | 1 | Mode select: 0 transmit, 1 receive |
| err_clr | input | 1 | One-cycle strobe that clears the error flag |
| cpu_wr | input | 1 | Processor write strobe (transmit mode) |
| cpu_wdata | input | W | Processor write word |
| cpu_rd | input | 1 | Processor read strobe (receive mode) |
| cpu_rdata | output | W | Oldest held word |
| fs_evt | input | 1 | Frame-sync strobe; one word transfer per pulse |
| ser_rx_word | input | W | Word delivered by the serial side in receive mode |
| ser_tx_word | output | W | Word handed to the serial side in transmit mode |
| buf_stat | output | 2 | Fill code: 00 empty, 10 one word, 11 full |
| err_flag | output | 1 | Sticky underflow (transmit) or overflow (receive) flag |

## Verification
The bench runs every combination of mode, starting fill, processor action and frame-sync. After each case it drains the buffer and compares every remaining word with its own queue model. A design that overwrote the oldest word on overflow would show up as a changed first read. A design that dropped the new word would show up as a stale second read. A design that only counted fill changes one at a time would show the wrong fill code when a transfer and an access coincide. The bench also checks three more cases: an underflow must not change the transmit word, an error must win over a clear in the same cycle, and processor accesses in the wrong mode must change nothing.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

  typedef enum logic [1:0] {
    FILL_NONE = 2'b00,
    FILL_PART = 2'b10,
    FILL_FULL = 2'b11
  } fill_code_e;

  // Three-state fill code derived from the word count.
  function automatic fill_code_e fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0)          return FILL_NONE;
    else if (cnt >= depth) return FILL_FULL;
    else                   return FILL_PART;
  endfunction

  // Net fill change for one cycle: one word in, one word out, or both.
  function automatic int unsigned net_count(input int unsigned cnt, input logic inc, input logic dec);
    return cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

endpackage

// File: rtl/fcb_store.sv
module fcb_store #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic         ovwr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] head
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [W-1:0]     slot [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign last_ptr = ptr_dec(wr_ptr);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic hit;
      assign hit = (push && wr_ptr == PTR_W'(i)) || (ovwr && last_ptr == PTR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot[i] <= '0;
        else if (hit) slot[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
    end
  end

  assign head = slot[rd_ptr];

endmodule

// File: rtl/fcb_ctrl.sv
module fcb_ctrl
  import fcb_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             is_rx,
  input  logic             err_clr,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             fs_evt,
  output logic             push,
  output logic             pop,
  output logic             ovwr,
  output logic             tx_pop,
  output logic             unf_evt,
  output logic             ovf_evt,
  output logic [CNT_W-1:0] count,
  output logic             err_flag
);

  logic empty, full, tx_mode, rx_mode;
  logic tx_push, rx_push, rx_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign tx_mode = enable && !is_rx;
  assign rx_mode = enable &&  is_rx;

  // Transmit side: processor fills, frame sync drains.
  assign tx_push = tx_mode && cpu_wr && !full;
  assign tx_pop  = tx_mode && fs_evt && !empty;
  assign unf_evt = tx_mode && fs_evt &&  empty;

  // Receive side: frame sync fills, processor drains.
  assign rx_pop  = rx_mode && cpu_rd && !empty;
  assign rx_push = rx_mode && fs_evt && (!full || rx_pop);
  assign ovf_evt = rx_mode && fs_evt && full && !rx_pop;

  assign push = tx_push || rx_push;
  assign pop  = tx_pop  || rx_pop;
  assign ovwr = ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!enable) count <= '0;
    else              count <= CNT_W'(net_count(int'(count), push, pop));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err_flag <= 1'b0;
    else if (!enable)             err_flag <= 1'b0;
    else if (unf_evt || ovf_evt)  err_flag <= 1'b1;
    else if (err_clr)             err_flag <= 1'b0;
  end

endmodule

// File: rtl/fsync_chan_buf.sv
module fsync_chan_buf
  import fcb_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         is_rx,
  input  logic         err_clr,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  input  logic         cpu_rd,
  output logic [W-1:0] cpu_rdata,
  input  logic         fs_evt,
  input  logic [W-1:0] ser_rx_word,
  output logic [W-1:0] ser_tx_word,
  output logic [1:0]   buf_stat,
  output logic         err_flag
);

  logic             push, pop, ovwr, tx_pop, unf_evt, ovf_evt;
  logic [CNT_W-1:0] count;
  logic [W-1:0]     head, wdata;

  fcb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_rx(is_rx), .err_clr(err_clr),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .fs_evt(fs_evt),
    .push(push), .pop(pop), .ovwr(ovwr), .tx_pop(tx_pop),
    .unf_evt(unf_evt), .ovf_evt(ovf_evt), .count(count), .err_flag(err_flag)
  );

  assign wdata = is_rx ? ser_rx_word : cpu_wdata;

  fcb_store #(.W(W), .DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .flush(!enable),
    .push(push), .pop(pop), .ovwr(ovwr), .wdata(wdata), .head(head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ser_tx_word <= '0;
    else if (!enable) ser_tx_word <= '0;
    else if (tx_pop)  ser_tx_word <= head;
  end

  assign cpu_rdata = head;
  assign buf_stat  = fill_code(int'(count), DEPTH);

endmodule

// File: rtl/fcb_checks.sv
module fcb_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         is_rx,
  input logic         err_clr,
  input logic         cpu_wr,
  input logic         fs_evt,
  input logic         tx_pop,
  input logic         unf_evt,
  input logic         ovf_evt,
  input logic [W-1:0] ser_tx_word,
  input logic [1:0]   buf_stat,
  input logic         err_flag
);

  assert_stat_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_stat != 2'b01);

  assert_tx_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !tx_pop |=> $stable(ser_tx_word));

  assert_underflow_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> err_flag);

  assert_overflow_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> err_flag && buf_stat == 2'b11);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && err_flag && !err_clr |=> err_flag);

  assert_full_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !is_rx && buf_stat == 2'b11 && cpu_wr && !fs_evt |=> buf_stat == 2'b11);

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> buf_stat == 2'b00 && !err_flag);

endmodule

bind fsync_chan_buf fcb_checks #(.W(W)) i_checks (
  .clk(clk), .rst_n(rst_n), .enable(enable), .is_rx(is_rx), .err_clr(err_clr),
  .cpu_wr(cpu_wr), .fs_evt(fs_evt), .tx_pop(tx_pop), .unf_evt(unf_evt),
  .ovf_evt(ovf_evt), .ser_tx_word(ser_tx_word), .buf_stat(buf_stat), .err_flag(err_flag)
);

// File: tb/test_fsync_chan_buf.sv
`timescale 1ns/1ps
module test_fsync_chan_buf;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0, is_rx = 1'b0, err_clr = 1'b0;
  logic         cpu_wr = 1'b0, cpu_rd = 1'b0, fs_evt = 1'b0;
  logic [W-1:0] cpu_wdata = '0, ser_rx_word = '0;
  logic [W-1:0] cpu_rdata, ser_tx_word;
  logic [1:0]   buf_stat;
  logic         err_flag;

  int checks = 0;
  int errors = 0;

  fsync_chan_buf #(.W(W), .DEPTH(2)) i_fsync_chan_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .is_rx(is_rx), .err_clr(err_clr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .fs_evt(fs_evt), .ser_rx_word(ser_rx_word), .ser_tx_word(ser_tx_word),
    .buf_stat(buf_stat), .err_flag(err_flag)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench-side fill code: high bit = any word held, low bit = both slots held.
  function automatic logic [1:0] exp_code(input int n);
    return {n > 0, n > 1};
  endfunction

  task automatic idle();
    cpu_wr = 0; cpu_rd = 0; fs_evt = 0; err_clr = 0;
  endtask

  logic [W-1:0] mq [4];
  int           mn;

  task automatic mq_shift();
    for (int k = 0; k < 3; k++) mq[k] = mq[k+1];
    mn--;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] exp_tx, nw, base;
    logic wr_ok, rd_ok, pop, push, ovf, unf;
    int nc;
    repeat (3) tick();
    // R1: reset values
    chk("R1 stat", buf_stat, 2'b00);
    chk("R1 err", err_flag, 1'b0);
    chk("R1 txword", ser_tx_word, '0);
    rst_n = 1;
    tick();

    // Sweep: mode x starting fill x processor action x frame sync
    for (int mode = 0; mode < 2; mode++)
      for (int fill = 0; fill < 3; fill++)
        for (int op = 0; op < 3; op++)
          for (int fs = 0; fs < 2; fs++) begin
            base = W'(16'h1000 * (1 + mode*18 + fill*6 + op*2 + fs));
            nw   = base ^ 16'h0A50;
            idle(); is_rx = mode[0]; enable = 0; tick();
            chk("R10 flush", buf_stat, 2'b00);
            enable = 1;
            mn = 0;
            for (int i = 0; i < fill; i++) begin
              if (mode == 0) begin cpu_wr = 1; cpu_wdata = base + W'(i); end
              else           begin fs_evt = 1; ser_rx_word = base + W'(i); end
              tick(); idle();
              mq[mn] = base + W'(i); mn++;
            end
            chk("R2 fill", buf_stat, exp_code(fill));
            cpu_wr = (op == 1); cpu_rd = (op == 2); fs_evt = fs[0];
            cpu_wdata = nw; ser_rx_word = nw;
            tick(); idle();
            exp_tx = '0;
            if (mode == 0) begin
              wr_ok = (op == 1) && (mn < 2);
              pop   = fs[0] && (mn > 0);
              unf   = fs[0] && (mn == 0);
              if (pop) begin exp_tx = mq[0]; mq_shift(); end
              if (wr_ok) begin mq[mn] = nw; mn++; end
              chk(op == 1 && fs == 1 ? "R8 tx net" : (op == 1 && fill == 2 ? "R9 full write" : "R3 tx stat"),
                  buf_stat, exp_code(mn));
              chk(unf ? "R4 underflow err" : "R3 tx err", err_flag, unf);
              chk(unf ? "R4 txword held" : "R3 txword", ser_tx_word, exp_tx);
              while (mn > 0) begin
                fs_evt = 1; tick(); idle();
                chk("R3 order", ser_tx_word, mq[0]);
                mq_shift();
              end
            end else begin
              rd_ok = (op == 2) && (mn > 0);
              ovf   = fs[0] && (mn == 2) && !rd_ok;
              push  = fs[0] && !ovf;
              nc = mn;
              if (rd_ok) mq_shift();
              if (push) begin mq[mn] = nw; mn++; end
              if (ovf) mq[mn-1] = nw;
              chk(op == 2 && fs == 1 ? "R8 rx net" : (op == 2 && nc == 0 ? "R9 empty read" : "R5 rx stat"),
                  buf_stat, exp_code(mn));
              chk(ovf ? "R6 overflow err" : "R5 rx err", err_flag, ovf);
              while (mn > 0) begin
                chk(ovf ? "R6 kept data" : "R5 rdata", cpu_rdata, mq[0]);
                cpu_rd = 1; tick(); idle();
                mq_shift();
              end
            end
            chk("R2 drained", buf_stat, 2'b00);
          end

    // R7: stickiness, clear, and set-over-clear priority (transmit underflow)
    is_rx = 0; enable = 0; tick(); enable = 1;
    fs_evt = 1; tick(); idle();
    repeat (3) tick();
    chk("R7 sticky", err_flag, 1'b1);
    err_clr = 1; tick(); idle();
    chk("R7 clear", err_flag, 1'b0);
    fs_evt = 1; err_clr = 1; tick(); idle();
    chk("R7 set wins", err_flag, 1'b1);

    // R9: wrong-mode accesses
    cpu_wr = 1; cpu_wdata = 16'h7777; tick(); idle();
    cpu_rd = 1; tick(); idle();
    chk("R9 tx read ignored", buf_stat, 2'b10);
    is_rx = 1; enable = 0; tick(); enable = 1;
    cpu_wr = 1; cpu_wdata = 16'h1234; tick(); idle();
    chk("R9 rx write ignored", buf_stat, 2'b00);

    // R10: disabled channel ignores traffic and clears state
    fs_evt = 1; ser_rx_word = 16'h5555; tick(); tick(); fs_evt = 1; tick(); idle();
    chk("R10 pre err", err_flag, 1'b1);
    enable = 0; fs_evt = 1; cpu_rd = 1; tick(); tick(); idle();
    chk("R10 stat", buf_stat, 2'b00);
    chk("R10 err", err_flag, 1'b0);
    is_rx = 0; cpu_wr = 1; fs_evt = 1; tick(); idle();
    chk("R10 txword", ser_tx_word, '0);
    chk("R10 write ignored", buf_stat, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule